// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex clocked serial shifter that runs from the system oscillator clock. Each transfer moves one 8-bit byte, least significant bit first. The block drives a shift clock pin, and every bit cell on that clock lasts a fixed 12 oscillator clocks. Data travels on one bidirectional data pin, which is modelled here as three separate signals: a data output, an output enable and a data input.

The host asks for a transfer with a single-cycle request. A transmit request loads the parallel byte, and the block then drives the data pin and places each bit a fixed number of oscillator clocks ahead of a rising shift-clock edge. A receive request releases the data pin and samples it at each rising shift-clock edge. At the end of a receive, the assembled byte is offered on a parallel output. In both directions the block raises a one-cycle completion pulse on the last rising edge. The block ignores any request that arrives while a transfer is in progress.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `sclk` is 1, `sd_oe` is 0, `busy` is 0, `done` is 0 and `rx_byte` is 0.
- R2: A request taken while idle sets `busy` on the next clock edge. During the transfer `sclk` makes exactly 8 rising transitions. Each low phase of `sclk` lasts 6 clocks, and consecutive rising transitions are 12 clocks apart.
- R3: In a transmit, the value on `sd_out` at the k-th rising transition of `sclk` (k = 0..7) is bit k of the byte that was loaded, so bit 0 goes first.
- R4: In a transmit, `sd_out` holds the same value for at least the 10 clock cycles that come before each rising transition of `sclk`.
- R5: In a transmit, `sd_out` stays unchanged for at least 2 clock cycles, counted from the cycle in which `sclk` rises.
- R6: In a receive, `sd_oe` is 0 for the whole transfer. `sd_in` is sampled at each rising transition of `sclk`, and the 8 samples are stored in `rx_byte`, the first sample in bit 0. `rx_byte` is updated when the transfer ends.
- R7: In a receive, the external device may change `sd_in` at any time from 1 to 10 clocks after a rising transition. Such a change does not alter the bit sampled at that transition, and the new value is the one sampled at the next transition.
- R8: `done` is 1 for exactly one clock cycle, which is the cycle in which `sclk` makes its eighth rising transition. `busy` falls 2 cycles after that rising transition.
- R9: A request made while `busy` is 1 is ignored: the transfer runs on without a restart and without loading the new byte.
- R10: If `start_tx` and `start_rx` arrive in the same idle cycle, the block performs a transmit.
- R11: Whenever `busy` is 0, `sclk` is 1 and `sd_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_tx | input | 1 | Transmit request (one cycle) |
| start_rx | input | 1 | Receive request (one cycle) |
| tx_byte | input | DATA_W | Byte to transmit, loaded when the request is taken |
| sd_in | input | 1 | Data pin input |
| sclk | output | 1 | Shift clock, high while idle |
| sd_out | output | 1 | Data pin output value |
| sd_oe | output | 1 | Data pin output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-byte pulse |
| rx_byte | output | DATA_W | Last received byte |

## Verification
Two events can coincide with the completion pulse: a fresh request, and the final rising edge of the shift clock. The bench raises a request carrying a different byte in exactly the `done` cycle, and also at random points mid-transfer. It then expects no restart: the remaining bits and edge count stay unchanged, and `busy` still falls 2 cycles after the last edge. The next transfer is started in the first idle cycle, so the bench can judge whether the block accepts a request right after the previous one ends.

// File: rtl/ssp_pkg.sv
// Package: shared types for the synchronous shift port.
// Assumes: nothing beyond IEEE 1800-2017.
package ssp_pkg;
    typedef enum logic {
        XF_TX = 1'b0,
        XF_RX = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/ssp_bit_timer.sv
// Module: bit-cell timer. Counts oscillator clocks inside a bit cell and
// bit cells inside a byte, and decodes the shift-clock low window and the
// cell events. Assumes `clear` and `run` never matter in the same cycle.
module ssp_bit_timer #(
    parameter int DATA_W       = 8,
    parameter int CLKS_PER_BIT = 12,
    parameter int SETUP_CLKS   = 10,
    parameter int LOW_CLKS     = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clear,
    input  logic                            run,
    output logic [$clog2(CLKS_PER_BIT)-1:0] phase_o,
    output logic [$clog2(DATA_W)-1:0]       bit_o,
    output logic                            rise_o,
    output logic                            slot_end_o,
    output logic                            last_bit_o,
    output logic                            low_win_o
);
    localparam int PH_W    = $clog2(CLKS_PER_BIT);
    localparam int BIT_W   = $clog2(DATA_W);
    localparam int LOW_BEG = SETUP_CLKS - LOW_CLKS;
    localparam int LOW_END = SETUP_CLKS - 1;

    logic [PH_W-1:0]  phase_q;
    logic [BIT_W-1:0] bit_q;

    // Advance the phase within a cell and the cell index within a byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            bit_q   <= '0;
        end else if (clear) begin
            phase_q <= '0;
            bit_q   <= '0;
        end else if (run) begin
            if (phase_q == PH_W'(CLKS_PER_BIT - 1)) begin
                phase_q <= '0;
                bit_q   <= bit_q + 1'b1;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    // Decode cell events from the counters.
    always_comb begin
        rise_o     = (phase_q == PH_W'(LOW_END));
        slot_end_o = (phase_q == PH_W'(CLKS_PER_BIT - 1));
        last_bit_o = (bit_q == BIT_W'(DATA_W - 1));
        low_win_o  = (phase_q >= PH_W'(LOW_BEG)) && (phase_q <= PH_W'(LOW_END));
    end

    assign phase_o = phase_q;
    assign bit_o   = bit_q;
endmodule

// File: rtl/ssp_shifter.sv
// Module: shared data shift register. Shifts right at the end of each cell
// when sending. When receiving, it shifts the pin value into the top bit at
// each rising shift-clock edge. Assumes the events come from ssp_bit_timer.
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  xfer_dir_e         dir,
    input  logic              run,
    input  logic              rise,
    input  logic              slot_end,
    input  logic              last_bit,
    input  logic              sd_in,
    output logic              sd_bit_o,
    output logic [DATA_W-1:0] rx_byte_o
);
    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] shift_in;

    // Value the register takes when it captures the pin.
    always_comb shift_in = {sd_in, shreg_q[DATA_W-1:1]};

    // Load, then shift out or shift in depending on direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (load) begin
            shreg_q <= load_val;
        end else if (run) begin
            if (dir == XF_TX && slot_end) begin
                shreg_q <= {1'b0, shreg_q[DATA_W-1:1]};
            end else if (dir == XF_RX && rise) begin
                shreg_q <= shift_in;
            end
        end
    end

    // Publish the received byte on the final sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (run && dir == XF_RX && rise && last_bit) begin
            rx_q <= shift_in;
        end
    end

    assign sd_bit_o  = shreg_q[0];
    assign rx_byte_o = rx_q;
endmodule

// File: rtl/sync_shift_port.sv
// Module: top of the synchronous shift port. Accepts a transmit or receive
// request while idle, sequences one byte with the bit timer and shifter,
// and pulses done on the last rising shift-clock edge.
// Assumes: requests are single-cycle, and transmit wins a tie.
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int CLKS_PER_BIT = 12,
    parameter int SETUP_CLKS   = 10,
    parameter int LOW_CLKS     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_tx,
    input  logic              start_rx,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              sd_in,
    output logic              sclk,
    output logic              sd_out,
    output logic              sd_oe,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int PH_W  = $clog2(CLKS_PER_BIT);
    localparam int BIT_W = $clog2(DATA_W);

    xfer_dir_e        dir_q;
    logic             busy_q;
    logic             done_q;
    logic             accept;
    logic [PH_W-1:0]  phase_q;
    logic [BIT_W-1:0] bit_q;
    logic             ev_rise;
    logic             ev_slot_end;
    logic             ev_last;
    logic             low_win;
    logic             sd_bit;
    logic             dir_is_rx;

    // A request is taken only while idle.
    always_comb accept = !busy_q && (start_tx || start_rx);

    // Control: busy, direction and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            dir_q  <= XF_TX;
            done_q <= 1'b0;
        end else begin
            done_q <= busy_q && ev_rise && ev_last;
            if (accept) begin
                busy_q <= 1'b1;
                dir_q  <= start_tx ? XF_TX : XF_RX;
            end else if (busy_q && ev_slot_end && ev_last) begin
                busy_q <= 1'b0;
            end
        end
    end

    ssp_bit_timer #(
        .DATA_W      (DATA_W),
        .CLKS_PER_BIT(CLKS_PER_BIT),
        .SETUP_CLKS  (SETUP_CLKS),
        .LOW_CLKS    (LOW_CLKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .run       (busy_q),
        .phase_o   (phase_q),
        .bit_o     (bit_q),
        .rise_o    (ev_rise),
        .slot_end_o(ev_slot_end),
        .last_bit_o(ev_last),
        .low_win_o (low_win)
    );

    ssp_shifter #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (tx_byte),
        .dir      (dir_q),
        .run      (busy_q),
        .rise     (ev_rise),
        .slot_end (ev_slot_end),
        .last_bit (ev_last),
        .sd_in    (sd_in),
        .sd_bit_o (sd_bit),
        .rx_byte_o(rx_byte)
    );

    // Pin outputs: clock low only inside the window, drive only when sending.
    always_comb begin
        dir_is_rx = (dir_q == XF_RX);
        sclk      = !(busy_q && low_win);
        sd_oe     = busy_q && !dir_is_rx;
        sd_out    = sd_oe ? sd_bit : 1'b1;
    end

    assign busy = busy_q;
    assign done = done_q;
endmodule

// File: rtl/ssp_checker.sv
// Module: property checker for sync_shift_port, attached by bind.
// Assumes: it sees the top ports plus the phase, cell index and direction.
module ssp_checker #(
    parameter int DATA_W       = 8,
    parameter int CLKS_PER_BIT = 12
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            start_tx,
    input logic                            start_rx,
    input logic                            sclk,
    input logic                            sd_out,
    input logic                            sd_oe,
    input logic                            busy,
    input logic                            done,
    input logic [$clog2(CLKS_PER_BIT)-1:0] phase_q,
    input logic [$clog2(DATA_W)-1:0]       bit_q,
    input logic                            dir_is_rx
);
    localparam int PH_W  = $clog2(CLKS_PER_BIT);
    localparam int BIT_W = $clog2(DATA_W);

    // R11: the clock is high and the pin is released while idle
    a_r11_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk && !sd_oe));

    // R2: the shift clock goes low only during a transfer
    a_r2_low_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk |-> busy);

    // R6: no drive during a receive
    a_r6_rx_released: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dir_is_rx) |-> !sd_oe);

    // R4: sent data changes only at the start of a bit cell
    a_r4_change_at_cell_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(sd_out)) |-> (phase_q == '0));

    // R5: sent data holds in the cycle after the rising edge
    a_r5_hold_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) && sd_oe) |=> $stable(sd_out));

    // R8: done comes with the rise of the last cell and lasts one cycle
    a_r8_done_on_last_rise: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($rose(sclk) && bit_q == BIT_W'(DATA_W - 1)));
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a request while busy does not restart the phase count
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (start_tx || start_rx) && phase_q != PH_W'(CLKS_PER_BIT - 1))
        |=> (phase_q == $past(phase_q) + 1'b1));
endmodule

bind sync_shift_port ssp_checker #(
    .DATA_W      (DATA_W),
    .CLKS_PER_BIT(CLKS_PER_BIT)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_tx (start_tx),
    .start_rx (start_rx),
    .sclk     (sclk),
    .sd_out   (sd_out),
    .sd_oe    (sd_oe),
    .busy     (busy),
    .done     (done),
    .phase_q  (phase_q),
    .bit_q    (bit_q),
    .dir_is_rx(dir_is_rx)
);

// File: tb/sync_shift_port_tb_top.sv
`timescale 1ns/1ps
module sync_shift_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_tx = 1'b0;
    logic       start_rx = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       sd_in = 1'b1;
    logic       sclk, sd_out, sd_oe, busy, done;
    logic [7:0] rx_byte;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    sync_shift_port dut_i (
        .clk(clk), .rst_n(rst_n), .start_tx(start_tx), .start_rx(start_rx),
        .tx_byte(tx_byte), .sd_in(sd_in), .sclk(sclk), .sd_out(sd_out),
        .sd_oe(sd_oe), .busy(busy), .done(done), .rx_byte(rx_byte)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected bit of a byte at a given cell index (bit 0 goes first).
    function automatic logic exp_bit(input logic [7:0] d, input int k);
        return d[k];
    endfunction

    // One transfer, called at a falling clock edge; returns at the first idle sample.
    task automatic xfer(input bit do_tx, input bit do_rx, input logic [7:0] d, input bit poke_done);
        bit   is_rx = do_rx && !do_tx;
        int   rises = 0, since = 0, run = -1, pend = 0, dones = 0, guard = 0, lowc = 0;
        int   poke_at = $urandom_range(5, 90);
        logic prev_s = 1'b1, prev_o, rval = 1'b0;
        bit   hold_chk = 1'b0;
        if (is_rx) sd_in = d[0];
        tx_byte  = d;
        start_tx = do_tx;
        start_rx = do_rx;
        @(negedge clk);
        start_tx = 1'b0;
        start_rx = 1'b0;
        chk(busy == 1'b1, "R2 accept", int'(busy), 1);
        if (do_tx && do_rx) chk(sd_oe == 1'b1, "R10 tie gives transmit", int'(sd_oe), 1);
        prev_o = sd_out;
        while (busy && guard < 200) begin
            guard++;
            since++;
            if (sd_out == prev_o) run++; else run = 0;
            prev_o = sd_out;
            chk(sd_oe == !is_rx, is_rx ? "R6 oe" : "R3 oe", int'(sd_oe), int'(!is_rx));
            if (hold_chk) begin
                chk(sd_out == rval, "R5 hold", int'(sd_out), int'(rval));
                hold_chk = 1'b0;
            end
            if (!sclk) lowc++;
            if (!prev_s && sclk) begin
                rises++;
                chk(lowc == 6, "R2 low width", lowc, 6);
                lowc = 0;
                if (rises > 1) chk(since == 12, "R2 period", since, 12);
                since = 0;
                if (!is_rx) begin
                    chk(sd_out == exp_bit(d, rises - 1), "R3 bit", int'(sd_out), int'(exp_bit(d, rises - 1)));
                    chk(run >= 10, "R4 setup", run, 10);
                    rval = sd_out;
                    hold_chk = 1'b1;
                end else if (rises < 8) begin
                    pend = $urandom_range(1, 10);
                end
                chk(done == (rises == 8), "R8 done at rise", int'(done), int'(rises == 8));
            end else begin
                chk(done == 1'b0, "R8 stray done", int'(done), 0);
            end
            if (done) dones++;
            if (is_rx && pend > 0) begin
                pend--;
                if (pend == 0) sd_in = d[rises];
            end
            if ((poke_done && done) || guard == poke_at) begin
                tx_byte  = ~d;
                start_tx = 1'b1;
                start_rx = !do_rx;
            end else begin
                start_tx = 1'b0;
                start_rx = 1'b0;
            end
            prev_s = sclk;
            @(negedge clk);
        end
        start_tx = 1'b0;
        start_rx = 1'b0;
        chk(rises == 8, "R2 R9 edge count", rises, 8);
        chk(dones == 1, "R8 done count", dones, 1);
        chk(since + 1 == 2, "R8 busy fall", since + 1, 2);
        chk(sclk == 1'b1 && sd_oe == 1'b0, "R11 idle pins", int'({sclk, sd_oe}), 2);
        if (is_rx) chk(rx_byte == d, "R6 R7 rx byte", int'(rx_byte), int'(d));
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sclk == 1'b1, "R1 sclk", int'(sclk), 1);
        chk(sd_oe == 1'b0, "R1 oe", int'(sd_oe), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(rx_byte == 8'h00, "R1 rx_byte", int'(rx_byte), 0);
        // directed corners
        xfer(1'b1, 1'b0, 8'h00, 1'b0);
        xfer(1'b1, 1'b0, 8'hFF, 1'b1);
        xfer(1'b1, 1'b0, 8'hA5, 1'b1);
        xfer(1'b0, 1'b1, 8'h01, 1'b1);
        xfer(1'b0, 1'b1, 8'h80, 1'b0);
        xfer(1'b1, 1'b1, 8'h3C, 1'b1);
        // random mix, some back to back, some with idle gaps
        for (int i = 0; i < 40; i++) begin
            int gap = $urandom_range(0, 3);
            int md  = $urandom_range(0, 2);
            repeat (gap) begin
                chk(sclk == 1'b1 && sd_oe == 1'b0, "R11 gap", int'({sclk, sd_oe}), 2);
                @(negedge clk);
            end
            xfer(md != 1, md != 0, 8'($urandom), bit'($urandom_range(0, 1)));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule